// File: doc/BRIEF.md
# Parallel Instruction Boundary Resolver

This block receives a fetch group of four 32-bit words from the instruction cache, together with the index of the word where execution enters the group. It marks which words begin instructions. For every instruction start it also marks which later words are displacement extensions and which are constant extensions. Downstream parse logic uses these masks to send each instruction, with its extension words, to a decoder.

Every word position gets its own small size decoder. Each decoder assumes its word is an instruction start and produces a unary pointer to the following start, plus its extension masks. A doubling tree then composes these pointers, so the real starts reachable from the entry offset are found in logarithmic depth rather than by a serial walk.

When the last instruction's extensions run past the end of the group, a spill count tells the fetch side how many words to skip in the next group. Groups enter on a valid/ready stream and leave one cycle later on a second valid/ready stream. The input can stall only when the output register holds an unconsumed result. While `out_valid` is high and `out_ready` is low, the result holds still and `in_ready` is low.

Top module: `insn_boundary_resolver`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A group accepted on a clock edge (`in_valid && in_ready`) appears on the outputs, with `out_valid` high, right after that edge.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and every result output keep their values at the next edge.
- R3: After reset `out_valid` is low.
- R4: Word i is `in_words[32*i+31:32*i]`. A word whose bits [31:29] equal 3'b001 is variable length: its displacement count is {bit15,bit14} and its constant count is {bit13,bit11}. Any other word is a single-word instruction, whatever its bits 15..11 are.
- R5: At most three extension words are allowed. When the two counts add up to more than three, the constant count is reduced to three minus the displacement count.
- R6: `out_starts` bit i marks word i as an instruction start. The entry offset is always a start, and no word below it is a start. Each later start lies directly after the previous instruction's last word.
- R7: For the start at word s, the slice `out_disp[4*s+3:4*s]` marks its displacement words and `out_const[4*s+3:4*s]` marks its constant words. The displacement words immediately follow the start, and the constant words follow the displacements. Positions past word 3 are not marked.
- R8: `out_spill` gives the number of extension words of the last start in the group that fall beyond word 3 (range 0 to 3).
- R9: The mask slices of words that are not starts are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch group present |
| in_ready | output | 1 | Block can take a group this cycle |
| in_words | input | 128 | Four instruction words, word 0 in the low bits |
| in_offset | input | 2 | Index of the first instruction word in the group |
| out_valid | output | 1 | Result registered and presented |
| out_ready | input | 1 | Consumer takes the result |
| out_starts | output | 4 | Instruction-start mask |
| out_disp | output | 16 | Displacement masks, one 4-bit slice per start |
| out_const | output | 16 | Constant masks, one 4-bit slice per start |
| out_spill | output | 2 | Extension words of the last instruction beyond the group |

## Verification
The handshake allows a new group to be accepted in the same cycle the previous result drains: `out_valid` and `out_ready` are both high, and with them `in_valid`. The bench drives `in_valid` and `out_ready` at random, so back-to-back transfers, drains into an empty register and long stalls all occur in a mix. Every accepted group is queued with an expected result computed by a serial walk over the words, and the queue is popped only on an output transfer. A lost, duplicated or overwritten result therefore shows up as a mismatch. During a stall the presented result is compared against its value in the previous cycle.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [2:0] VAR_OPC = 3'b001;
  localparam int unsigned MAX_EXT = 3;

  typedef struct packed {
    logic [1:0] dsp;
    logic [1:0] cst;
  } ext_cnt_t;

  // Size fields of one word, with the total number of extensions capped.
  function automatic ext_cnt_t size_fields(input logic [WORD_W-1:0] w);
    ext_cnt_t e;
    if (w[31:29] == VAR_OPC) begin
      e.dsp = {w[15], w[14]};
      e.cst = {w[13], w[11]};
      if ({1'b0, e.dsp} + {1'b0, e.cst} > 3'(MAX_EXT))
        e.cst = 2'(MAX_EXT) - e.dsp;
    end else begin
      e = '0;
    end
    return e;
  endfunction
endpackage

// File: rtl/ibr_word_len.sv
module ibr_word_len
  import ibr_pkg::*;
#(
  parameter int NW  = 4,
  parameter int POS = 0
) (
  input  logic [WORD_W-1:0] word,
  output logic [NW:0]       next_oh,
  output logic [NW-1:0]     disp_m,
  output logic [NW-1:0]     cnst_m,
  output logic [1:0]        spill
);
  ext_cnt_t ec;
  int       last_d;
  int       last_c;

  always_comb begin
    ec     = size_fields(word);
    last_d = POS + int'(ec.dsp);
    last_c = last_d + int'(ec.cst);
    for (int k = 0; k < NW; k++) begin
      disp_m[k] = (k > POS) && (k <= last_d);
      cnst_m[k] = (k > last_d) && (k <= last_c);
    end
    for (int k = 0; k <= NW; k++)
      next_oh[k] = (k == NW) ? (last_c + 1 >= NW) : (last_c + 1 == k);
    spill = (last_c + 1 > NW) ? 2'(last_c + 1 - NW) : 2'd0;
  end
endmodule

// File: rtl/ibr_chain.sv
module ibr_chain #(
  parameter int NW    = 4,
  parameter int OFF_W = $clog2(NW)
) (
  input  logic [NW-1:0][NW:0] nxt,
  input  logic [OFF_W-1:0]    offset,
  output logic [NW-1:0]       starts
);
  localparam int LV = $clog2(NW);

  // Level l: reach covers 0..2^l-1 hops; jump table covers 2^l hops.
  always_comb begin
    logic [NW:0][NW:0] jm;
    logic [NW:0][NW:0] jn;
    logic [NW:0]       rc;
    logic [NW:0]       rn;
    for (int i = 0; i < NW; i++) jm[i] = nxt[i];
    jm[NW]     = '0;
    jm[NW][NW] = 1'b1;
    for (int i = 0; i <= NW; i++) rc[i] = (i == int'(offset));
    for (int l = 0; l < LV; l++) begin
      rn = rc;
      jn = '0;
      for (int k = 0; k <= NW; k++)
        for (int j = 0; j <= NW; j++) begin
          if (rc[k] && jm[k][j]) rn[j] = 1'b1;
          for (int i = 0; i <= NW; i++)
            if (jm[i][k] && jm[k][j]) jn[i][j] = 1'b1;
        end
      rc = rn;
      jm = jn;
    end
    starts = rc[NW-1:0];
  end
endmodule

// File: rtl/insn_boundary_resolver.sv
module insn_boundary_resolver
  import ibr_pkg::*;
#(
  parameter int NW    = 4,
  parameter int OFF_W = $clog2(NW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NW*WORD_W-1:0] in_words,
  input  logic [OFF_W-1:0]     in_offset,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NW-1:0]        out_starts,
  output logic [NW*NW-1:0]     out_disp,
  output logic [NW*NW-1:0]     out_const,
  output logic [1:0]           out_spill
);
  logic [NW-1:0][NW:0]   nxt;
  logic [NW-1:0][NW-1:0] dm;
  logic [NW-1:0][NW-1:0] cm;
  logic [NW-1:0][1:0]    sp;
  logic [NW-1:0]         starts_c;
  logic [NW-1:0]         ends_c;
  logic [NW-1:0]         last_c;
  logic [NW*NW-1:0]      disp_c;
  logic [NW*NW-1:0]      cnst_c;
  logic [1:0]            spill_c;
  logic                  take;

  for (genvar g = 0; g < NW; g++) begin : g_pos
    ibr_word_len #(.NW(NW), .POS(g)) u_len (
      .word    (in_words[g*WORD_W +: WORD_W]),
      .next_oh (nxt[g]),
      .disp_m  (dm[g]),
      .cnst_m  (cm[g]),
      .spill   (sp[g])
    );
    assign ends_c[g] = nxt[g][NW];
  end

  ibr_chain #(.NW(NW), .OFF_W(OFF_W)) u_chain (
    .nxt    (nxt),
    .offset (in_offset),
    .starts (starts_c)
  );

  always_comb begin
    last_c  = starts_c & ends_c;
    spill_c = '0;
    for (int i = 0; i < NW; i++) begin
      disp_c[i*NW +: NW] = starts_c[i] ? dm[i] : '0;
      cnst_c[i*NW +: NW] = starts_c[i] ? cm[i] : '0;
      if (last_c[i]) spill_c = spill_c | sp[i];
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_starts <= '0;
      out_disp   <= '0;
      out_const  <= '0;
      out_spill  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_starts <= starts_c;
        out_disp   <= disp_c;
        out_const  <= cnst_c;
        out_spill  <= spill_c;
      end
    end
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);  // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_starts) &&
      $stable(out_disp) && $stable(out_const) && $stable(out_spill)));  // R2
  AST_ENTRY_START: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> starts_c[in_offset]);  // R6
  AST_ONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones(last_c) == 1));  // R8
  AST_EXT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((disp_c & cnst_c) == '0));  // R7
endmodule

// File: tb/insn_boundary_resolver_tb.sv
module insn_boundary_resolver_tb;
  typedef struct packed {
    logic [3:0]  st;
    logic [15:0] dsp;
    logic [15:0] cst;
    logic [1:0]  spl;
  } res_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_words = '0;
  logic [1:0]   in_offset = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [3:0]   out_starts;
  logic [15:0]  out_disp;
  logic [15:0]  out_const;
  logic [1:0]   out_spill;

  int   n_chk = 0;
  int   n_bad = 0;
  res_t expq[$];
  string tagq[$];
  logic  was_stall = 1'b0;
  res_t  held;

  always #5 clk = ~clk;

  insn_boundary_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_words(in_words), .in_offset(in_offset), .out_valid(out_valid),
    .out_ready(out_ready), .out_starts(out_starts), .out_disp(out_disp),
    .out_const(out_const), .out_spill(out_spill)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Serial walk over the words (R4, R5, R6, R7, R8, R9).
  function automatic res_t model(input logic [127:0] d, input logic [1:0] off);
    res_t r = '0;
    int pos = int'(off);
    while (pos < 4) begin
      logic [31:0] w = d[pos*32 +: 32];
      int dd = 0;
      int cc = 0;
      if (w[31:29] == 3'b001) begin
        dd = {w[15], w[14]};
        cc = {w[13], w[11]};
        if (dd + cc > 3) cc = 3 - dd;
      end
      r.st[pos] = 1'b1;
      for (int k = 1; k <= dd + cc; k++)
        if (pos + k < 4) begin
          if (k <= dd) r.dsp[pos*4 + pos + k] = 1'b1;
          else         r.cst[pos*4 + pos + k] = 1'b1;
        end
      pos = pos + 1 + dd + cc;
    end
    r.spl = 2'(pos - 4);
    return r;
  endfunction

  function automatic res_t cur_out();
    res_t r;
    r.st = out_starts; r.dsp = out_disp; r.cst = out_const; r.spl = out_spill;
    return r;
  endfunction

  task automatic step(input logic v, input logic [127:0] d, input logic [1:0] off,
                      input logic rdy, input res_t e, input string tag);
    @(negedge clk);
    in_valid = v; in_words = d; in_offset = off; out_ready = rdy;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R1", "in_ready",
        32'(in_ready), 32'(!out_valid || out_ready));
    if (was_stall) begin
      chk(out_valid == 1'b1, "R2", "valid held", 32'(out_valid), 32'd1);
      chk(cur_out() == held, "R2", "result held", 32'(cur_out()), 32'(held));
    end
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R1", "unexpected output", 32'd1, 32'd0);
      end else begin
        res_t x = expq.pop_front();
        string t = tagq.pop_front();
        chk(out_starts == x.st,  {"R6 ", t}, "starts", 32'(out_starts), 32'(x.st));
        chk(out_disp   == x.dsp, {"R7 R9 ", t}, "disp", 32'(out_disp), 32'(x.dsp));
        chk(out_const  == x.cst, {"R7 R9 ", t}, "const", 32'(out_const), 32'(x.cst));
        chk(out_spill  == x.spl, {"R8 ", t}, "spill", 32'(out_spill), 32'(x.spl));
      end
    end
    was_stall = out_valid && !out_ready;
    held = cur_out();
    if (v && in_ready) begin
      expq.push_back(e);
      tagq.push_back(tag);
    end
  endtask

  task automatic directed(input logic [127:0] d, input logic [1:0] off,
                          input res_t e, input string tag);
    step(1'b1, d, off, 1'b1, e, tag);
    step(1'b0, '0, '0, 1'b1, '0, "");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    res_t e;
    logic [127:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R3", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R3", "out_valid after reset", 32'(out_valid), 32'd0);

    // R4: variable form, 1 disp + 1 const, then single word at 3
    d = {32'h0, 32'h1111_1111, 32'h2222_2222, 32'h2000_4800};
    e = '{st: 4'b1001, dsp: 16'h0002, cst: 16'h0004, spl: 2'd0};
    directed(d, 2'd0, e, "R4 var");
    // R4: size bits ignored outside the variable opcode group
    d = {4{32'h4000_E800}};
    e = '{st: 4'b1111, dsp: 16'h0, cst: 16'h0, spl: 2'd0};
    directed(d, 2'd0, e, "R4 fixed");
    // R5: 3 disp + 3 const clamps to 3 disp
    d = {32'h0, 32'h0, 32'h0, 32'h2000_E800};
    e = '{st: 4'b0001, dsp: 16'h000E, cst: 16'h0, spl: 2'd0};
    directed(d, 2'd0, e, "R5 clamp");
    // R8: start at 2, 2 disp + 1 const, spills 2
    d = {32'h0, 32'h2000_8800, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    e = '{st: 4'b0100, dsp: 16'h0800, cst: 16'h0, spl: 2'd2};
    directed(d, 2'd2, e, "R8 spill2");
    // R6: entry at last word, one constant spills
    d = {32'h2000_0800, 32'h2000_E800, 32'h0, 32'h0};
    e = '{st: 4'b1000, dsp: 16'h0, cst: 16'h0, spl: 2'd1};
    directed(d, 2'd3, e, "R6 off3");

    // Random traffic with back-pressure
    for (int n = 0; n < 600; n++) begin
      logic [1:0] off = 2'($urandom_range(0, 3));
      for (int i = 0; i < 4; i++) begin
        d[i*32 +: 32] = $urandom;
        if ($urandom_range(0, 1) == 1) d[i*32 + 29 +: 3] = 3'b001;
      end
      step(($urandom_range(0, 9) < 7), d, off, ($urandom_range(0, 9) < 6),
           model(d, off), "rand");
    end
    for (int n = 0; n < 4; n++) step(1'b0, '0, '0, 1'b1, '0, "");
    chk(expq.size() == 0, "R1", "results drained", 32'(expq.size()), 32'd0);
    finish_run();
  end
endmodule